// File: doc/BRIEF.md
# Request Type Classifier with Locked-Pair Line Hold

This block sits between a requester and the outstanding-request tracker of a cache sequencer. Each incoming request carries a line address and a set of attribute flags: read, write, flush, instruction fetch, linked/conditional, locked and store-check. The block gives every request two type codes. The primary type selects which tracking table the request enters. The secondary type is what the cache controller is asked to do. When no rule covers the flag combination, the request is marked as unsupported.

The block also tracks locked read-modify-write pairs. A completion report for a locked read puts a hold on that line. The matching locked-write completion removes the hold. While a line is held, new requests to that line are refused by holding ready low. Requests to other lines pass through unchanged. Classification is combinational, so an accepted request appears on the output side in the same cycle it is offered.

Top module: `reqtype_classifier`

## Requirements
- R1: After reset no line is held: `req_ready` is high for every line and `out_valid` is low while `req_valid` is low.
- R2: When the linked/conditional flag is set, it takes priority over the other flags. With write set, the primary type is conditional-store (8). Otherwise, with read set, the primary type is linked-load (7). In both cases the secondary type is atomic (9).
- R3: When linked/conditional is clear and locked is set, the outcome depends on write and read. With write set, the primary type is locked-write (6). Otherwise, with read set, the primary type is locked-read (5). In both cases the secondary type is store (2).
- R4: For a plain request (neither linked/conditional nor locked) with read set, the fetch flag gives fetch (3) for both types. Fetch takes priority over store-check.
- R5: For a plain read that is not a fetch, store-check set gives primary RMW-read (4) with secondary store (2). Store-check clear gives load (1) for both types. For plain requests, read is checked before write.
- R6: A plain request with read clear and write set gives store (2) for both types. A plain request with read and write clear and flush set gives flush (10) for both types.
- R7: Any other flag combination is unsupported. The block asserts `out_err` and drives both type outputs to none (0).
- R8: A completion with type locked-read (5) holds its line from the next cycle. A request to a held line sees `req_ready` low and produces no `out_valid`. Requests to other lines are unaffected.
- R9: A completion with type locked-write (6) releases its line's hold from the next cycle. A completion of any other type, or a release of a line that is not held, changes no hold.
- R10: Holds on different lines are independent, up to `HOLD_SLOTS` at once. Releasing one held line leaves the others held.
- R11: `out_valid` equals `req_valid && req_ready`, and `out_line` carries `req_line` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted (low when its line is held) |
| req_line | input | LINE_W | Request line address |
| req_rd | input | 1 | Read flag |
| req_wr | input | 1 | Write flag |
| req_flush | input | 1 | Flush flag |
| req_fetch | input | 1 | Instruction-fetch flag |
| req_llsc | input | 1 | Linked/conditional flag |
| req_locked | input | 1 | Locked flag |
| req_stchk | input | 1 | Store-check flag |
| out_valid | output | 1 | Classified request towards the tracker |
| out_line | output | LINE_W | Line address of the classified request |
| out_prim | output | 4 | Primary type code |
| out_sec | output | 4 | Secondary type code |
| out_err | output | 1 | Unsupported flag combination |
| cmp_valid | input | 1 | Completion report |
| cmp_line | input | LINE_W | Completion line address |
| cmp_type | input | 4 | Primary type of the completed request |

## Verification
The bench targets the overlapping flag combinations where the priority order decides the result:
- linked/conditional together with locked;
- read together with write, both under linked/conditional and in plain requests;
- fetch together with store-check;
- write together with flush.

A design with the wrong priority gives a valid but wrong type code, and the scoreboard reports it as a miscompare.

The bench also probes hold timing and independence. It sets a hold, probes another line, sets two holds and releases one, sends a completion that is not a locked type, and releases a line that is not held. A table that clears the wrong slot, ignores a release, or reacts to other completion types either stalls a request it should accept or accepts one it should refuse.

// File: rtl/reqtype_classifier_pkg.sv
package reqtype_classifier_pkg;

    localparam int TYPE_W = 4;

    typedef enum logic [TYPE_W-1:0] {
        T_NONE   = 4'd0,
        T_LOAD   = 4'd1,
        T_STORE  = 4'd2,
        T_FETCH  = 4'd3,
        T_RMWRD  = 4'd4,
        T_LKRD   = 4'd5,
        T_LKWR   = 4'd6,
        T_LNKLD  = 4'd7,
        T_CONDST = 4'd8,
        T_ATOM   = 4'd9,
        T_FLUSH  = 4'd10
    } rq_type_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic flush;
        logic fetch;
        logic llsc;
        logic locked;
        logic stchk;
    } rq_attr_t;

    typedef struct packed {
        rq_type_e prim;
        rq_type_e sec;
        logic     bad;
    } rq_class_t;

    function automatic logic starts_hold(input logic [TYPE_W-1:0] t);
        return t == T_LKRD;
    endfunction

    function automatic logic ends_hold(input logic [TYPE_W-1:0] t);
        return t == T_LKWR;
    endfunction

endpackage

// File: rtl/rqc_decode.sv
module rqc_decode
    import reqtype_classifier_pkg::*;
(
    input  rq_attr_t  attr,
    output rq_class_t cls
);
    always_comb begin
        cls = '{prim: T_NONE, sec: T_NONE, bad: 1'b1};
        if (attr.llsc) begin
            if (attr.wr)      cls = '{prim: T_CONDST, sec: T_ATOM,  bad: 1'b0};
            else if (attr.rd) cls = '{prim: T_LNKLD,  sec: T_ATOM,  bad: 1'b0};
        end else if (attr.locked) begin
            if (attr.wr)      cls = '{prim: T_LKWR,   sec: T_STORE, bad: 1'b0};
            else if (attr.rd) cls = '{prim: T_LKRD,   sec: T_STORE, bad: 1'b0};
        end else if (attr.rd) begin
            if (attr.fetch)      cls = '{prim: T_FETCH, sec: T_FETCH, bad: 1'b0};
            else if (attr.stchk) cls = '{prim: T_RMWRD, sec: T_STORE, bad: 1'b0};
            else                 cls = '{prim: T_LOAD,  sec: T_LOAD,  bad: 1'b0};
        end else if (attr.wr) begin
            cls = '{prim: T_STORE, sec: T_STORE, bad: 1'b0};
        end else if (attr.flush) begin
            cls = '{prim: T_FLUSH, sec: T_FLUSH, bad: 1'b0};
        end
    end
endmodule

// File: rtl/rqc_hold_table.sv
module rqc_hold_table #(
    parameter int LINE_W = 16,
    parameter int SLOTS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [LINE_W-1:0] upd_line,
    input  logic [LINE_W-1:0] probe_line,
    output logic              probe_hit
);
    logic [SLOTS-1:0]  vld;
    logic [LINE_W-1:0] tag [SLOTS];
    logic [SLOTS-1:0]  upd_match;
    logic [SLOTS-1:0]  probe_match;
    logic [SLOTS-1:0]  free_1h;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            upd_match[i]   = vld[i] && (tag[i] == upd_line);
            probe_match[i] = vld[i] && (tag[i] == probe_line);
        end
    end

    assign free_1h   = ~vld & (vld + 1'b1);
    assign probe_hit = |probe_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (clr_en && upd_match[i]) begin
                    vld[i] <= 1'b0;
                end else if (set_en && !(|upd_match) && free_1h[i]) begin
                    vld[i] <= 1'b1;
                    tag[i] <= upd_line;
                end
            end
        end
    end
endmodule

// File: rtl/reqtype_classifier.sv
module reqtype_classifier
    import reqtype_classifier_pkg::*;
#(
    parameter int LINE_W     = 16,
    parameter int HOLD_SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LINE_W-1:0] req_line,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic              req_flush,
    input  logic              req_fetch,
    input  logic              req_llsc,
    input  logic              req_locked,
    input  logic              req_stchk,
    output logic              out_valid,
    output logic [LINE_W-1:0] out_line,
    output logic [3:0]        out_prim,
    output logic [3:0]        out_sec,
    output logic              out_err,
    input  logic              cmp_valid,
    input  logic [LINE_W-1:0] cmp_line,
    input  logic [3:0]        cmp_type
);
    rq_attr_t  attr;
    rq_class_t cls;
    logic      line_held;

    assign attr = '{rd: req_rd, wr: req_wr, flush: req_flush, fetch: req_fetch,
                    llsc: req_llsc, locked: req_locked, stchk: req_stchk};

    rqc_decode u_dec (
        .attr (attr),
        .cls  (cls)
    );

    rqc_hold_table #(.LINE_W(LINE_W), .SLOTS(HOLD_SLOTS)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .set_en     (cmp_valid && starts_hold(cmp_type)),
        .clr_en     (cmp_valid && ends_hold(cmp_type)),
        .upd_line   (cmp_line),
        .probe_line (req_line),
        .probe_hit  (line_held)
    );

    assign req_ready = !line_held;
    assign out_valid = req_valid && req_ready;
    assign out_line  = req_line;
    assign out_prim  = cls.prim;
    assign out_sec   = cls.sec;
    assign out_err   = cls.bad;
endmodule

// File: rtl/reqtype_classifier_chk.sv
module reqtype_classifier_chk #(
    parameter int LINE_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LINE_W-1:0] req_line,
    input logic              req_llsc,
    input logic              req_locked,
    input logic              out_valid,
    input logic [3:0]        out_prim,
    input logic [3:0]        out_sec,
    input logic              out_err,
    input logic              cmp_valid,
    input logic [LINE_W-1:0] cmp_line,
    input logic [3:0]        cmp_type
);
    // R11
    handshake_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (req_valid && req_ready));

    // R7
    bad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> (out_prim == 4'd0 && out_sec == 4'd0));

    // R2
    llsc_atomic_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && req_llsc && !out_err) |-> (out_sec == 4'd9));

    // R3
    locked_store_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !req_llsc && req_locked && !out_err) |-> (out_sec == 4'd2));

    // R8
    hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_type == 4'd5) |=> (req_line != $past(cmp_line)) || !req_ready);

    // R9
    release_go_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_type == 4'd6) |=> (req_line != $past(cmp_line)) || req_ready);
endmodule

bind reqtype_classifier reqtype_classifier_chk #(.LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_line   (req_line),
    .req_llsc   (req_llsc),
    .req_locked (req_locked),
    .out_valid  (out_valid),
    .out_prim   (out_prim),
    .out_sec    (out_sec),
    .out_err    (out_err),
    .cmp_valid  (cmp_valid),
    .cmp_line   (cmp_line),
    .cmp_type   (cmp_type)
);

// File: tb/sim_reqtype_classifier.sv
module sim_reqtype_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 16;

    // attribute masks: {llsc, locked, fetch, stchk, rd, wr, flush}
    localparam logic [6:0] LL = 7'b1000000, LK = 7'b0100000, IF = 7'b0010000,
                           SC = 7'b0001000, RD = 7'b0000100, WR = 7'b0000010,
                           FL = 7'b0000001;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_ready;
    logic [LW-1:0] req_line = '0;
    logic [6:0] attr = '0;
    logic out_valid, out_err;
    logic [LW-1:0] out_line;
    logic [3:0] out_prim, out_sec;
    logic cmp_valid = 1'b0;
    logic [LW-1:0] cmp_line = '0;
    logic [3:0] cmp_type = '0;

    int checks = 0, fails = 0;
    bit finished = 0;

    typedef struct {
        logic [3:0] p;
        logic [3:0] s;
        logic e;
        logic [LW-1:0] l;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    reqtype_classifier #(.LINE_W(LW), .HOLD_SLOTS(4)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
        .req_rd(attr[2]), .req_wr(attr[1]), .req_flush(attr[0]),
        .req_fetch(attr[4]), .req_llsc(attr[6]), .req_locked(attr[5]),
        .req_stchk(attr[3]),
        .out_valid(out_valid), .out_line(out_line), .out_prim(out_prim),
        .out_sec(out_sec), .out_err(out_err),
        .cmp_valid(cmp_valid), .cmp_line(cmp_line), .cmp_type(cmp_type)
    );

    // monitor: pop and compare every accepted request
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R11 unexpected output: prim=%0d sec=%0d expected none", out_prim, out_sec);
            end else begin
                exp_t x;
                x = sb.pop_front();
                if (out_prim !== x.p || out_sec !== x.s || out_err !== x.e || out_line !== x.l) begin
                    fails++;
                    $display("FAIL %s: got prim=%0d sec=%0d err=%0b line=%h, expected prim=%0d sec=%0d err=%0b line=%h",
                             x.tag, out_prim, out_sec, out_err, out_line, x.p, x.s, x.e, x.l);
                end
            end
        end
    end

    task automatic send(input logic [6:0] a, input logic [LW-1:0] ln,
                        input logic [3:0] ep, input logic [3:0] es,
                        input logic ee, input string tag);
        exp_t x;
        @(posedge clk); #1;
        x.p = ep; x.s = es; x.e = ee; x.l = ln; x.tag = tag;
        sb.push_back(x);
        attr = a; req_line = ln; req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic probe(input logic [LW-1:0] ln, input logic exp_rdy, input string tag);
        exp_t x;
        @(posedge clk); #1;
        if (exp_rdy) begin
            x.p = 4'd1; x.s = 4'd1; x.e = 1'b0; x.l = ln; x.tag = tag;
            sb.push_back(x);
        end
        attr = RD; req_line = ln; req_valid = 1'b1;
        @(negedge clk);
        checks++;
        if (req_ready !== exp_rdy || out_valid !== exp_rdy) begin
            fails++;
            $display("FAIL %s: ready=%0b out_valid=%0b, expected %0b", tag, req_ready, out_valid, exp_rdy);
        end
        #1 req_valid = 1'b0;
    endtask

    task automatic complete(input logic [3:0] t, input logic [LW-1:0] ln);
        @(posedge clk); #1;
        cmp_valid = 1'b1; cmp_type = t; cmp_line = ln;
        @(posedge clk); #1;
        cmp_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        checks++;
        if (req_ready !== 1'b1 || out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: ready=%0b out_valid=%0b expected 1 0", req_ready, out_valid);
        end
        probe(16'h0040, 1'b1, "R1 no hold after reset");

        send(LL|WR,    16'h0001, 4'd8, 4'd9, 1'b0, "R2 cond store");
        send(LL|RD,    16'h0002, 4'd7, 4'd9, 1'b0, "R2 linked load");
        send(LL|RD|WR, 16'h0003, 4'd8, 4'd9, 1'b0, "R2 write first");
        send(LL|LK|WR, 16'h0004, 4'd8, 4'd9, 1'b0, "R2 over locked");
        send(LK|WR,    16'h0005, 4'd6, 4'd2, 1'b0, "R3 locked write");
        send(LK|RD,    16'h0006, 4'd5, 4'd2, 1'b0, "R3 locked read");
        send(LK|RD|SC, 16'h0007, 4'd5, 4'd2, 1'b0, "R3 over stchk");
        send(RD|IF,    16'h0008, 4'd3, 4'd3, 1'b0, "R4 fetch");
        send(RD|IF|SC, 16'h0009, 4'd3, 4'd3, 1'b0, "R4 fetch over stchk");
        send(RD|SC,    16'h000a, 4'd4, 4'd2, 1'b0, "R5 rmw read");
        send(RD,       16'h000b, 4'd1, 4'd1, 1'b0, "R5 load");
        send(RD|WR,    16'h000c, 4'd1, 4'd1, 1'b0, "R5 read first");
        send(WR,       16'h000d, 4'd2, 4'd2, 1'b0, "R6 store");
        send(FL,       16'h000e, 4'd10, 4'd10, 1'b0, "R6 flush");
        send(WR|FL,    16'h000f, 4'd2, 4'd2, 1'b0, "R6 write over flush");
        send(7'b0,     16'h0010, 4'd0, 4'd0, 1'b1, "R7 no flags");
        send(LL|FL,    16'h0011, 4'd0, 4'd0, 1'b1, "R7 llsc flush");
        send(LK,       16'h0012, 4'd0, 4'd0, 1'b1, "R7 locked alone");
        send(IF,       16'h0013, 4'd0, 4'd0, 1'b1, "R7 fetch no read");
        send(RD,       16'hbeef, 4'd1, 4'd1, 1'b0, "R11 line passthrough");

        complete(4'd5, 16'h0aa0);
        probe(16'h0aa0, 1'b0, "R8 held line stalls");
        probe(16'h0bb0, 1'b1, "R8 other line passes");
        complete(4'd6, 16'h0aa0);
        probe(16'h0aa0, 1'b1, "R9 released line passes");
        complete(4'd1, 16'h0cc0);
        probe(16'h0cc0, 1'b1, "R9 load completion no hold");
        complete(4'd5, 16'h0d00);
        complete(4'd6, 16'h0e00);
        probe(16'h0d00, 1'b0, "R9 stray release keeps hold");
        complete(4'd5, 16'h0f00);
        complete(4'd6, 16'h0d00);
        probe(16'h0f00, 1'b0, "R10 other hold kept");
        probe(16'h0d00, 1'b1, "R10 released one passes");
        complete(4'd6, 16'h0f00);
        probe(16'h0f00, 1'b1, "R10 second release");

        repeat (3) @(posedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R11 %0d expected outputs never seen, expected 0", sb.size());
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule